// File: doc/BRIEF.md
# Asynchronous Character Receiver with Sticky Error Flags

This block turns an asynchronous serial line into parallel characters. The line is oversampled by a receive clock at 1, 16 or 64 ticks per bit. Each character is framed by a start bit and a stop bit, carries 5 to 8 data bits with the least significant bit first, and may include one parity bit. A finished character goes into a one-deep holding register and raises a ready flag. The ready flag drops when the processor strobes a read.

Three error flags report trouble on the line. A parity mismatch, a low stop bit, and a character that lands on an unread predecessor each set their own flag. Every error flag stays set until a clear pulse removes it. A separate break indicator rises when the line has been held low for two full character times. The indicator falls as soon as the line returns high. The line input `rxd` is taken to be synchronous to `clk`, and each `clk` edge counts as one receive-clock tick. The format inputs may only change while the line is idle.

Top module: `async_char_rx`

## Requirements
- R1: `factorSel` selects the ticks per bit: 2 selects 16, 3 selects 64, and 0 or 1 selects 1. In the 16 and 64 modes a start edge is confirmed half a bit later. Each following bit is sampled a whole bit period after the previous sample. In the 1 mode every tick after the start tick samples the next bit.
- R2: `charLen` selects 5 + `charLen` data bits (0 to 3 gives 5 to 8). The first data bit received lands in `rxData[0]`, and the bits above the character length read as zero.
- R3: When `parityOn` is 1, one parity bit follows the data. `parityEven` = 1 requires an even count of ones across the data and parity bits, and 0 requires an odd count. A mismatch sets `parityErr`. When `parityOn` is 0, no parity bit is expected and `parityErr` is not set.
- R4: A stop bit sampled low sets `framingErr`, and the character is still delivered.
- R5: A character that completes while `rxReady` is still 1 sets `overrunErr` and replaces the buffered character.
- R6: `parityErr`, `overrunErr` and `framingErr` stay set until an `errClr` pulse. A new error in the same cycle as the clear wins over the clear.
- R7: `rxReady` rises in the cycle after a character completes and falls after an `rdStrobe` pulse. A completion in the same cycle as the read wins over the read.
- R8: In the 16 and 64 modes, a low pulse that has ended by the start-bit midpoint is ignored. No character, flag or data change results from it.
- R9: While `rxEn` is 0, no character is assembled and the ready flag, data and error flags keep their values.
- R10: `breakDet` is 1 once `rxd` has been low for 2 × (2 + data bits + parity bit) × ticks-per-bit consecutive ticks. It drops on the tick after `rxd` is seen high.
- R11: After reset, `rxData` is zero and every flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one tick per edge |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEn | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line, idle high |
| factorSel | input | 2 | Ticks per bit select |
| charLen | input | 2 | Data bits minus five |
| parityOn | input | 1 | Parity bit present |
| parityEven | input | 1 | 1 = even sense, 0 = odd sense |
| errClr | input | 1 | Pulse that clears the three error flags |
| rdStrobe | input | 1 | Processor read of the data buffer |
| rxData | output | 8 | Buffered character, upper bits zero |
| rxReady | output | 1 | Unread character present |
| parityErr | output | 1 | Sticky parity mismatch |
| overrunErr | output | 1 | Sticky overrun |
| framingErr | output | 1 | Sticky low stop bit |
| breakDet | output | 1 | Line held low for two character times |

## Verification
A sampling counter that is off by one tick moves every later sample toward a bit edge. In the 1 mode the same fault shifts the character by a whole bit, so `rxData` and `framingErr` are wrong when that very frame completes. A wrong bit index or length decode shows up as a wrong upper bit or a spurious parity or framing error on the first frame of that length, which is why the bench sweeps every length, parity sense and tick factor. Faults in the flag logic, such as a clear that does not stick, a lost overrun or a break threshold off by a whole character, show up within one frame or one break window of the provoking stimulus.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DATA_W     = 8;
  localparam int MIN_BITS   = 5;
  localparam int MAX_FACTOR = 64;
  localparam int CNT_W      = $clog2(MAX_FACTOR);
  localparam int FAC_W      = CNT_W + 1;
  localparam int IDX_W      = $clog2(DATA_W + 2);
  localparam int SPAN       = DATA_W - MIN_BITS;
  localparam int BRK_W      = $clog2(2 * (DATA_W + 3) * MAX_FACTOR + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic clear;      // new frame begins: wipe shift register
    logic dataBit;    // sample rxd as the next data bit
    logic parityBit;  // sample rxd as the parity bit
    logic stopBit;    // sample rxd as the stop bit and commit the character
  } rxStrobe_t;

  function automatic logic [FAC_W-1:0] factorOf(input logic [1:0] sel);
    case (sel)
      2'd2:    factorOf = FAC_W'(16);
      2'd3:    factorOf = FAC_W'(64);
      default: factorOf = FAC_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/acr_ctrl.sv
module acr_ctrl
  import acr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxEn,
  input  logic            rxd,
  input  logic [1:0]      factorSel,
  input  logic [1:0]      charLen,
  input  logic            parityOn,
  output rxStrobe_t       strb
);
  rxState_t          state, stateNext;
  logic [CNT_W-1:0]  tickCnt, tickCntNext;
  logic [IDX_W-1:0]  bitIdx, bitIdxNext;
  logic              armed;
  logic              startGo;
  logic [FAC_W-1:0]  fac;
  logic [CNT_W-1:0]  fullLoad, halfLoad;
  logic [IDX_W-1:0]  dataBits, lastIdx;
  logic              singleTick;

  assign fac        = factorOf(factorSel);
  assign singleTick = (fac == FAC_W'(1));
  assign fullLoad   = CNT_W'(fac - FAC_W'(1));
  assign halfLoad   = CNT_W'((fac >> 1) - FAC_W'(1));
  assign dataBits   = IDX_W'(MIN_BITS) + IDX_W'(charLen);
  assign lastIdx    = dataBits + IDX_W'(parityOn) - IDX_W'(1);
  assign startGo    = (state == ST_IDLE) && rxEn && !rxd && armed;

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    strb        = '0;
    unique case (state)
      ST_IDLE: begin
        if (startGo) begin
          strb.clear  = 1'b1;
          bitIdxNext  = '0;
          if (singleTick) begin
            stateNext   = ST_BITS;
            tickCntNext = '0;
          end else begin
            stateNext   = ST_START;
            tickCntNext = halfLoad;
          end
        end
      end
      ST_START: begin
        if (tickCnt == '0) begin
          if (rxd) begin
            stateNext = ST_IDLE;
          end else begin
            stateNext   = ST_BITS;
            tickCntNext = fullLoad;
          end
        end else begin
          tickCntNext = tickCnt - CNT_W'(1);
        end
      end
      ST_BITS: begin
        if (tickCnt == '0) begin
          tickCntNext = fullLoad;
          if (bitIdx < dataBits) strb.dataBit = 1'b1;
          else                   strb.parityBit = 1'b1;
          if (bitIdx == lastIdx) stateNext = ST_STOP;
          else                   bitIdxNext = bitIdx + IDX_W'(1);
        end else begin
          tickCntNext = tickCnt - CNT_W'(1);
        end
      end
      ST_STOP: begin
        if (tickCnt == '0) begin
          strb.stopBit = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          tickCntNext = tickCnt - CNT_W'(1);
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (!rxEn) begin
      stateNext = ST_IDLE;
      strb      = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      armed   <= 1'b0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
      armed   <= rxd || (armed && !startGo);
    end
  end
endmodule

// File: rtl/acr_datapath.sv
module acr_datapath
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  input  logic [1:0]        factorSel,
  input  logic [1:0]        charLen,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              errClr,
  input  logic              rdStrobe,
  input  rxStrobe_t         strb,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              breakDet
);
  logic [DATA_W-1:0] shiftReg;
  logic              parSample;
  logic [3:0]        alignShift;
  logic [DATA_W-1:0] aligned;
  logic              parMismatch;
  logic [BRK_W-1:0]  lowCnt, brkLimit;
  logic [4:0]        frameBits;

  assign alignShift  = 4'(SPAN) - {2'b00, charLen};
  assign aligned     = shiftReg >> alignShift;
  assign parMismatch = parityOn && ((^shiftReg) ^ parSample ^ !parityEven);

  assign frameBits = 5'(MIN_BITS + 2) + {3'b000, charLen} + {4'b0000, parityOn};
  assign brkLimit  = (BRK_W'(frameBits) * BRK_W'(factorOf(factorSel))) << 1;
  assign breakDet  = (lowCnt >= brkLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parSample <= 1'b0;
    end else begin
      if (strb.clear)          shiftReg  <= '0;
      else if (strb.dataBit)   shiftReg  <= {rxd, shiftReg[DATA_W-1:1]};
      if (strb.parityBit)      parSample <= rxd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      rxReady    <= strb.stopBit || (rxReady && !rdStrobe);
      parityErr  <= (strb.stopBit && parMismatch) || (parityErr && !errClr);
      framingErr <= (strb.stopBit && !rxd)        || (framingErr && !errClr);
      overrunErr <= (strb.stopBit && rxReady)     || (overrunErr && !errClr);
      if (strb.stopBit) rxData <= aligned;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowCnt <= '0;
    else if (rxd)              lowCnt <= '0;
    else if (lowCnt < brkLimit) lowCnt <= lowCnt + BRK_W'(1);
  end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxd,
  input  logic [1:0]        factorSel,
  input  logic [1:0]        charLen,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              errClr,
  input  logic              rdStrobe,
  output logic [7:0]        rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              breakDet
);
  rxStrobe_t strb;

  acr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEn      (rxEn),
    .rxd       (rxd),
    .factorSel (factorSel),
    .charLen   (charLen),
    .parityOn  (parityOn),
    .strb      (strb)
  );

  acr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxd        (rxd),
    .factorSel  (factorSel),
    .charLen    (charLen),
    .parityOn   (parityOn),
    .parityEven (parityEven),
    .errClr     (errClr),
    .rdStrobe   (rdStrobe),
    .strb       (strb),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .parityErr  (parityErr),
    .overrunErr (overrunErr),
    .framingErr (framingErr),
    .breakDet   (breakDet)
  );
endmodule

// File: rtl/async_char_rx_chk.sv
module async_char_rx_chk (
  input logic clk,
  input logic rstN,
  input logic rxEn,
  input logic rxd,
  input logic errClr,
  input logic rdStrobe,
  input logic rxReady,
  input logic parityErr,
  input logic overrunErr,
  input logic framingErr,
  input logic breakDet,
  input logic commit
);
  a_r6_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr && !errClr |=> parityErr);
  a_r6_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    framingErr && !errClr |=> framingErr);
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr && !errClr |=> overrunErr);
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    errClr && !commit |=> !parityErr && !overrunErr && !framingErr);
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    commit && rxReady |=> overrunErr);
  a_r7_commit_sets: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> rxReady);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !commit |=> !rxReady);
  a_r9_enabled_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(rxEn));
  a_r10_break_release: assert property (@(posedge clk) disable iff (!rstN)
    rxd |=> !breakDet);
endmodule

bind async_char_rx async_char_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEn       (rxEn),
  .rxd        (rxd),
  .errClr     (errClr),
  .rdStrobe   (rdStrobe),
  .rxReady    (rxReady),
  .parityErr  (parityErr),
  .overrunErr (overrunErr),
  .framingErr (framingErr),
  .breakDet   (breakDet),
  .commit     (strb.stopBit)
);

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEn = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] factorSel = 2'd1;
  logic [1:0] charLen = 2'd3;
  logic       parityOn = 1'b0;
  logic       parityEven = 1'b0;
  logic       errClr = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, overrunErr, framingErr, breakDet;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  async_char_rx u_dut (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxd(rxd),
    .factorSel(factorSel), .charLen(charLen), .parityOn(parityOn),
    .parityEven(parityEven), .errClr(errClr), .rdStrobe(rdStrobe),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .framingErr(framingErr), .breakDet(breakDet)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ticksOf(input logic [1:0] sel);
    return (sel == 2'd2) ? 16 : (sel == 2'd3) ? 64 : 1;
  endfunction

  task automatic sendBit(input logic b);
    rxd = b;
    repeat (ticksOf(factorSel)) @(negedge clk);
  endtask

  task automatic idle(input int bits);
    rxd = 1'b1;
    repeat (bits * ticksOf(factorSel) + 2) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input bit badStop);
    int n;
    logic p;
    n = 5 + charLen;
    p = 1'b0;
    for (int i = 0; i < n; i++) p ^= d[i];
    if (!parityEven) p = ~p;
    sendBit(1'b0);
    for (int i = 0; i < n; i++) sendBit(d[i]);
    if (parityOn) sendBit(p ^ flipPar);
    sendBit(!badStop);
    idle(2);
  endtask

  task automatic pulseRead();
    rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulseClr();
    errClr = 1'b1; @(negedge clk); errClr = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, expD;
    int nVals;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rxData == 8'h00 && !rxReady && !parityErr && !overrunErr && !framingErr && !breakDet,
          "R11 reset state", {rxData, rxReady, parityErr, overrunErr, framingErr, breakDet}, 0);
    rstN = 1'b1;
    rxEn = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R7: sweep factors, lengths, parity modes and values
    for (int fs = 1; fs <= 3; fs++) begin
      factorSel = 2'(fs);
      nVals = (fs == 3) ? 3 : 4;
      for (int len = 0; len < 4; len++) begin
        charLen = 2'(len);
        for (int pm = 0; pm < 3; pm++) begin
          parityOn   = (pm != 0);
          parityEven = (pm == 2);
          idle(2);
          for (int v = 0; v < nVals; v++) begin
            bit flip, bad;
            d = (v == 0) ? 8'hFF : 8'((v * 8'h5B) + (len * 7) + pm * 3 + fs);
            flip = parityOn && (v == 1);
            bad  = (v == 2);
            sendFrame(d, flip, bad);
            expD = d & 8'((1 << (5 + len)) - 1);
            check(rxData == expD, "R1 R2 data and field alignment", rxData, expD);
            check(rxReady == 1'b1, "R7 ready after frame", rxReady, 1);
            check(parityErr == flip, "R3 parity check", parityErr, flip);
            check(framingErr == bad, "R4 framing check", framingErr, bad);
            check(!overrunErr, "R5 no overrun on single frame", overrunErr, 0);
            pulseRead();
            check(!rxReady, "R7 read clears ready", rxReady, 0);
            pulseClr();
          end
        end
      end
    end

    // R5 R6: overrun, stickiness, clear
    factorSel = 2'd2; charLen = 2'd3; parityOn = 1'b1; parityEven = 1'b1;
    idle(2);
    sendFrame(8'h3C, 1'b1, 1'b0);
    sendFrame(8'hA5, 1'b0, 1'b0);
    check(overrunErr, "R5 overrun set", overrunErr, 1);
    check(rxData == 8'hA5, "R5 newer character kept", rxData, 8'hA5);
    check(parityErr, "R6 parity error held across good frame", parityErr, 1);
    pulseRead();
    sendFrame(8'h11, 1'b0, 1'b0);
    check(overrunErr && parityErr, "R6 flags held without clear", {overrunErr, parityErr}, 3);
    pulseClr();
    check(!overrunErr && !parityErr && !framingErr, "R6 clear pulse", {overrunErr, parityErr, framingErr}, 0);
    check(rxReady, "R6 clear leaves ready", rxReady, 1);
    pulseRead();

    // R8: glitch rejection in x16 and x64
    for (int fs = 2; fs <= 3; fs++) begin
      factorSel = 2'(fs);
      idle(2);
      rxd = 1'b0;
      repeat (ticksOf(factorSel) / 2 - 3) @(negedge clk);
      idle(3);
      check(!rxReady && !framingErr && !parityErr, "R8 glitch ignored",
            {rxReady, framingErr, parityErr}, 0);
      sendFrame(8'h96, 1'b0, 1'b0);
      check(rxData == 8'h96 && !parityErr && !framingErr, "R8 frame after glitch", rxData, 8'h96);
      pulseRead();
    end

    // R9: disabled receiver ignores a frame
    factorSel = 2'd2;
    rxEn = 1'b0;
    sendFrame(8'h0F, 1'b1, 1'b1);
    check(!rxReady && rxData == 8'h96 && !parityErr && !framingErr, "R9 disabled frame ignored",
          {rxReady, rxData}, {1'b0, 8'h96});
    rxEn = 1'b1;
    idle(1);
    sendFrame(8'h5A, 1'b0, 1'b0);
    check(rxData == 8'h5A && !overrunErr, "R9 enabled frame received", rxData, 8'h5A);
    pulseRead();

    // R10: break detection, x1 8N (limit 20) and x16 7E (limit 2*10*16=320)
    factorSel = 2'd1; charLen = 2'd3; parityOn = 1'b0;
    idle(2);
    rxd = 1'b0;
    repeat (15) @(negedge clk);
    check(!breakDet, "R10 no break before two characters x1", breakDet, 0);
    repeat (10) @(negedge clk);
    check(breakDet, "R10 break after two characters x1", breakDet, 1);
    rxd = 1'b1;
    @(negedge clk);
    check(!breakDet, "R10 break drops on high line", breakDet, 0);
    idle(2); pulseRead(); pulseClr();

    factorSel = 2'd2; charLen = 2'd2; parityOn = 1'b1;
    idle(2);
    rxd = 1'b0;
    repeat (310) @(negedge clk);
    check(!breakDet, "R10 no break before limit x16", breakDet, 0);
    repeat (15) @(negedge clk);
    check(breakDet, "R10 break at limit x16", breakDet, 1);
    rxd = 1'b1;
    @(negedge clk);
    check(!breakDet, "R10 break release x16", breakDet, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule